// File: doc/BRIEF.md
# Soft Reset and Clock-Gate Sequencer

This block holds a single 32-bit control word for one peripheral. The word carries a soft-reset bit and a clock-gate bit, and it drives the peripheral's synchronous reset and clock-enable lines from them. Software reaches the word at three addresses. The plain address loads it. The SET address ORs in the bits written as ones. The CLR address removes the bits written as ones.

When software raises soft reset, a small state machine counts a fixed number of cycles and then turns the clock-gate bit on by itself. Software polls for that bit before it releases reset. After release, software clears the clock-gate bit as a separate step and waits for it to read back 0. Both bits stay readable in every state. A real clock-gating cell is not part of this block; the clock-enable output stands in for it.

The states are `ST_RUN`, `ST_WAIT` and `ST_HELD`:
- `ST_RUN` is the normal state with reset low.
- `ST_WAIT` is the countdown after reset rises.
- `ST_HELD` means reset is set and gating has been forced on.

The transitions are:
- RUN→WAIT when the reset bit is seen high.
- WAIT→HELD when the count expires with reset still high.
- WAIT→RUN when reset is cleared early (abort).
- HELD→RUN when reset is seen low.

Top module: `srst_gate_ctrl`

## Requirements
- R1: After the hardware reset `bus_rdata` reads 0, `blk_srst` is 0 and `blk_clk_en` is 1.
- R2: A write to byte offset 0x0 loads bit 31 (soft reset) and bit 30 (clock gate) from `bus_wdata`; bits 29..0 always read 0.
- R3: A write to offset 0x4 sets the bits among 31 and 30 that are written as one. A write to offset 0x8 clears them. Bits written as zero keep their value. A write to offset 0xC changes nothing.
- R4: The clock-gate bit becomes 1 by itself on the GATE_DELAY-th clock edge after the edge that set soft reset (default 4), provided soft reset stays 1 throughout. It reads 0 before that edge unless software set it.
- R5: If soft reset is cleared before the delay expires, the clock-gate bit is not set automatically.
- R6: `blk_srst` equals the soft-reset bit, and `blk_clk_en` is the inverse of the clock-gate bit, in every cycle.
- R7: Once gating has been forced on, a software clear of the clock-gate bit is overridden while soft reset remains 1 after that write.
- R8: Clearing soft reset leaves the clock-gate bit at 1 until software clears it. After that clear, `blk_clk_en` returns to 1.
- R9: Software may set the clock-gate bit directly with soft reset low, which drops `blk_clk_en` without asserting `blk_srst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte offset: 0x0 plain, 0x4 SET, 0x8 CLR |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Control word read value |
| blk_srst | output | 1 | Synchronous reset to the peripheral |
| blk_clk_en | output | 1 | Clock enable to the peripheral |

## Verification
Two cases are hard to reach from the ports. One is a clock-gate clear that lands on the same edge as the automatic set or during the held state. The other is a soft-reset clear that arrives one cycle before the count expires. Directed sequences place a clear exactly at those cycles. A long stretch of random writes then mixes all three aliases with idle gaps of random length, so reset is often raised and dropped inside the countdown window. Each cycle is compared against a bench model that tracks how many edges soft reset has been held.

// File: rtl/srst_gate_pkg.sv
package srst_gate_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 4;
    localparam int SRST_BIT = 31;
    localparam int GATE_BIT = 30;

    localparam logic [ADDR_W-1:0] OFS_PLAIN = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_SET   = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 4'h8;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_WAIT = 2'd1,
        ST_HELD = 2'd2
    } seq_state_t;
endpackage

// File: rtl/srst_gate_decode.sv
module srst_gate_decode
    import srst_gate_pkg::*;
(
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cur_srst,
    input  logic              cur_gate,
    output logic              sw_srst,
    output logic              sw_gate
);
    logic w_srst;
    logic w_gate;

    assign w_srst = wdata[SRST_BIT];
    assign w_gate = wdata[GATE_BIT];

    always_comb begin
        sw_srst = cur_srst;
        sw_gate = cur_gate;
        if (wr) begin
            unique case (addr)
                OFS_PLAIN: begin
                    sw_srst = w_srst;
                    sw_gate = w_gate;
                end
                OFS_SET: begin
                    sw_srst = cur_srst | w_srst;
                    sw_gate = cur_gate | w_gate;
                end
                OFS_CLR: begin
                    sw_srst = cur_srst & ~w_srst;
                    sw_gate = cur_gate & ~w_gate;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/srst_gate_seq.sv
module srst_gate_seq
    import srst_gate_pkg::*;
#(
    parameter int GATE_DELAY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_srst,
    input  logic sw_gate,
    output logic srst_q,
    output logic gate_q,
    output logic blk_srst,
    output logic blk_clk_en
);
    localparam int CNT_W = $clog2(GATE_DELAY + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GATE_DELAY - 1);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             gate_d;

    initial begin
        if (GATE_DELAY < 2) $error("GATE_DELAY must be at least 2");
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        gate_d  = sw_gate;
        unique case (state_q)
            ST_RUN: begin
                if (srst_q) begin
                    state_d = ST_WAIT;
                    cnt_d   = CNT_W'(1);
                end
            end
            ST_WAIT: begin
                if (!srst_q) begin
                    state_d = ST_RUN;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = ST_HELD;
                    gate_d  = 1'b1;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            ST_HELD: begin
                if (!srst_q) begin
                    state_d = ST_RUN;
                end else begin
                    gate_d = sw_gate | sw_srst;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
            srst_q  <= 1'b0;
            gate_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            srst_q  <= sw_srst;
            gate_q  <= gate_d;
        end
    end

    always_comb begin
        blk_srst   = srst_q;
        blk_clk_en = ~gate_q;
    end

    p_auto_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && srst_q && cnt_q == CNT_LAST) |=> gate_q);

    p_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !srst_q) |=> (state_q == ST_RUN));

    p_override_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD && srst_q && sw_srst) |=> gate_q);

    p_gate_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(srst_q) && gate_q && sw_gate) |=> gate_q);
endmodule

// File: rtl/srst_gate_ctrl.sv
module srst_gate_ctrl
    import srst_gate_pkg::*;
#(
    parameter int GATE_DELAY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              blk_srst,
    output logic              blk_clk_en
);
    logic srst_q;
    logic gate_q;
    logic sw_srst;
    logic sw_gate;

    srst_gate_decode u_dec (
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .cur_srst (srst_q),
        .cur_gate (gate_q),
        .sw_srst  (sw_srst),
        .sw_gate  (sw_gate)
    );

    srst_gate_seq #(.GATE_DELAY(GATE_DELAY)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_srst    (sw_srst),
        .sw_gate    (sw_gate),
        .srst_q     (srst_q),
        .gate_q     (gate_q),
        .blk_srst   (blk_srst),
        .blk_clk_en (blk_clk_en)
    );

    always_comb begin
        bus_rdata           = '0;
        bus_rdata[SRST_BIT] = srst_q;
        bus_rdata[GATE_BIT] = gate_q;
    end

    p_set_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_SET && bus_wdata[SRST_BIT]) |=> blk_srst);

    p_clr_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CLR && bus_wdata[SRST_BIT]) |=> !blk_srst);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(blk_srst));

    p_outputs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_clk_en != bus_rdata[GATE_BIT]) && (blk_srst == bus_rdata[SRST_BIT]));
endmodule

// File: tb/sim_srst_gate_ctrl.sv
`timescale 1ns/1ps
module sim_srst_gate_ctrl;
    localparam int D = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        blk_srst;
    logic        blk_clk_en;

    int n_chk = 0;
    int n_bad = 0;

    logic m_rst = 1'b0;
    logic m_gate = 1'b0;
    int   m_age = 0;

    always #4 clk = ~clk;

    srst_gate_ctrl #(.GATE_DELAY(D)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .blk_srst(blk_srst), .blk_clk_en(blk_clk_en)
    );

    function automatic logic [31:0] word_of(logic r, logic g);
        return {r, g, 30'd0};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        check({tag, " R2 rdata"}, bus_rdata, word_of(m_rst, m_gate));
        check({tag, " R6 srst"}, {31'd0, blk_srst}, {31'd0, m_rst});
        check({tag, " R6 clk_en"}, {31'd0, blk_clk_en}, {31'd0, ~m_gate});
    endtask

    // one clock: drive at negedge, update model, compare at the next negedge
    task automatic cycle(input logic wr, input logic [3:0] a, input logic [31:0] d, input string tag);
        logic sr, sg, ng;
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        sr = m_rst; sg = m_gate;
        if (wr) begin
            case (a)
                4'h0: begin sr = d[31]; sg = d[30]; end
                4'h4: begin sr = m_rst | d[31]; sg = m_gate | d[30]; end
                4'h8: begin sr = m_rst & ~d[31]; sg = m_gate & ~d[30]; end
                default: ;
            endcase
        end
        if (m_rst && m_age == D - 1) ng = 1'b1;
        else if (m_rst && m_age >= D) ng = sg | sr;
        else ng = sg;
        @(posedge clk);
        m_age  = m_rst ? ((m_age < D) ? m_age + 1 : D) : 0;
        m_rst  = sr;
        m_gate = ng;
        @(negedge clk);
        bus_wr = 1'b0;
        check_all(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", bus_rdata, 32'h0);
        check("R1 srst", {31'd0, blk_srst}, 32'd0);
        check("R1 clk_en", {31'd0, blk_clk_en}, 32'd1);

        // R2 / R9 plain write of gate only; low bits dropped
        cycle(1'b1, 4'h0, 32'h7FFF_FFFF, "R9 plain gate");
        check("R9 gate only", bus_rdata, 32'h4000_0000);
        check("R9 clk_en low", {31'd0, blk_clk_en}, 32'd0);
        // R3 ignored offset
        cycle(1'b1, 4'hC, 32'h8000_0000, "R3 offset C");
        check("R3 offset C ignored", bus_rdata, 32'h4000_0000);
        cycle(1'b1, 4'h8, 32'h4000_0000, "R3 clr gate");
        check("R3 clr gate", bus_rdata, 32'h0);

        // R4 auto gate timing
        cycle(1'b1, 4'h4, 32'h8000_0000, "R4 set srst");
        for (int j = 1; j <= D + 1; j++) begin
            cycle(1'b0, 4'h0, 32'h0, "R4 wait");
            check("R4 gate timing", {31'd0, bus_rdata[30]}, {31'd0, (j >= D)});
        end
        // R7 override
        cycle(1'b1, 4'h8, 32'h4000_0000, "R7 clr gate held");
        check("R7 override", bus_rdata, 32'hC000_0000);
        // R8 release reset, gate stays
        cycle(1'b1, 4'h8, 32'h8000_0000, "R8 clr srst");
        check("R8 gate kept", bus_rdata, 32'h4000_0000);
        cycle(1'b0, 4'h0, 32'h0, "R8 idle");
        cycle(1'b1, 4'h8, 32'h4000_0000, "R8 clr gate");
        check("R8 clk_en back", {31'd0, blk_clk_en}, 32'd1);

        // R5 abort one cycle before expiry
        cycle(1'b1, 4'h4, 32'h8000_0000, "R5 set srst");
        for (int j = 1; j < D - 1; j++) cycle(1'b0, 4'h0, 32'h0, "R5 wait");
        cycle(1'b1, 4'h8, 32'h8000_0000, "R5 abort");
        for (int j = 0; j < D + 2; j++) cycle(1'b0, 4'h0, 32'h0, "R5 after");
        check("R5 no gate", bus_rdata, 32'h0);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] a;
            logic [31:0] d;
            a = 4'(($urandom % 4) * 4);
            d = {$urandom, 30'd0} | 32'($urandom);
            if ($urandom % 3 == 0) cycle(1'b1, a, d, "R3 random write");
            else cycle(1'b0, 4'h0, 32'h0, "R4 random idle");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule